// File: doc/BRIEF.md
# Multi-Register Store Sequencer

This block turns one start command into a burst of 32-bit memory writes, one for each register picked by a 16-bit select mask. The register file holds eight data registers and eight address registers, and the block receives all sixteen as one flat input bus. When it accepts a start, it forms a 24-bit start address from the low bits of a chosen address register plus a sign-extended displacement. It then walks the mask from the lowest selected register to the highest and writes each one to the next word in memory.

The engine keeps two internal counters for the whole operation. One is the set of registers still pending, and the other is the memory pointer. Unselected registers cost no cycles, because the next pending register is found combinationally every cycle. The memory side has an address, write data, a write enable and a ready input. A write takes effect only in a cycle where the write enable and ready are both high, so a slow memory can stall the burst for as long as it needs. The block flags `done` for one cycle when nothing remains, and then returns to idle.

Top module: `regstore_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are low.
- R2: The start address is the low 24 bits of address register A[`base_sel`] plus `disp`, sign-extended from 16 bits, taken modulo 2^24. A[k] is `regs_in[(8+k)*32 +: 32]`.
- R3: Mask bit k (0..7) selects data register D[k] = `regs_in[k*32 +: 32]`, and mask bit 8+k selects A[k]. Selected registers are written in ascending bit order, each with its own register value as `mem_wdata`.
- R4: Each accepted write advances the address by 4 modulo 2^24, so the words occupy consecutive, wrapping locations.
- R5: Unselected registers take no cycles. With `mem_ready` held high, n selected registers are written in the n cycles right after the start cycle, and `done` is high in cycle n+1.
- R6: A write counts only in a cycle where `mem_we` and `mem_ready` are both high. While `mem_ready` is low, the address and the register being written are held.
- R7: `done` is high for exactly one cycle, once no selected register remains. In the next cycle `busy` is low.
- R8: An all-zero mask produces no writes and raises `done` in the cycle after the start.
- R9: A `start` that arrives while `busy` is high is ignored. The burst in progress keeps its mask, its addresses and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mask | input | 16 | Register select: bits 0..7 data regs, 8..15 address regs |
| base_sel | input | 3 | Index of the address register used as base |
| disp | input | 16 | Signed displacement added to the base |
| regs_in | input | 512 | All sixteen registers, register i at bits i*32 +: 32 |
| mem_addr | output | 24 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | Write request |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench checks a sparse mask with a 0x28 displacement, a negative displacement and a full mask. A design that scanned bits in the wrong order, or spent a cycle on each cleared bit, would write words out of order or finish late. Memory stalls from an irregular ready pattern test whether the pointer moves only on accepted writes; an early increment shows up as skipped addresses. A base near the top of the 24-bit space tests the address wrap. An all-zero mask tests whether `done` comes one cycle after the start, and a start injected mid-burst tests whether a design restarts or corrupts the burst instead of ignoring the request.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int NREG_P  = 16;
  localparam int DW_P    = 32;
  localparam int AW_P    = 24;
  localparam int DISPW_P = 16;
  localparam int IW_P    = $clog2(NREG_P);

  function automatic logic [AW_P-1:0] start_addr(input logic [AW_P-1:0] base,
                                                 input logic [DISPW_P-1:0] disp);
    logic [AW_P-1:0] ext;
    ext = {{(AW_P-DISPW_P){disp[DISPW_P-1]}}, disp};
    return base + ext;
  endfunction

  function automatic logic [AW_P-1:0] step_addr(input logic [AW_P-1:0] ptr);
    return ptr + AW_P'(DW_P/8);
  endfunction

  function automatic logic [IW_P-1:0] oh_to_idx(input logic [NREG_P-1:0] oh);
    logic [IW_P-1:0] r;
    r = '0;
    for (int i = 0; i < NREG_P; i++)
      if (oh[i]) r = r | IW_P'(i);
    return r;
  endfunction
endpackage

// File: rtl/rss_mask_scan.sv
module rss_mask_scan #(
  parameter int NREG = rss_pkg::NREG_P
) (
  input  logic [NREG-1:0] pend,
  output logic [NREG-1:0] first_oh,
  output logic            any
);
  logic [NREG:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    assign seen[i+1]   = seen[i] | pend[i];
    assign first_oh[i] = pend[i] & ~seen[i];
  end

  assign any = seen[NREG];
endmodule

// File: rtl/rss_addr_gen.sv
module rss_addr_gen #(
  parameter int AW = rss_pkg::AW_P
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= rss_pkg::step_addr(ptr);
  end
endmodule

// File: rtl/regstore_seq.sv
module regstore_seq #(
  parameter int NREG  = rss_pkg::NREG_P,
  parameter int DW    = rss_pkg::DW_P,
  parameter int AW    = rss_pkg::AW_P,
  parameter int DISPW = rss_pkg::DISPW_P
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NREG-1:0]      mask,
  input  logic [2:0]           base_sel,
  input  logic [DISPW-1:0]     disp,
  input  logic [NREG*DW-1:0]   regs_in,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_we,
  input  logic                 mem_ready,
  output logic                 busy,
  output logic                 done
);
  localparam int HALF = NREG / 2;
  localparam int IW   = $clog2(NREG);

  logic            busy_q;
  logic [NREG-1:0] pend_q;
  logic [NREG-1:0] sel_oh;
  logic            sel_any;
  logic [IW-1:0]   sel_idx;
  logic            accept;
  logic            wr_fire;
  logic [AW-1:0]   base_val;
  logic [AW-1:0]   first_addr;

  rss_mask_scan #(.NREG(NREG)) u_scan (
    .pend(pend_q), .first_oh(sel_oh), .any(sel_any)
  );

  assign sel_idx    = IW'(rss_pkg::oh_to_idx(sel_oh));
  assign accept     = start && !busy_q;
  assign wr_fire    = mem_we && mem_ready;
  assign base_val   = regs_in[(HALF + int'(base_sel))*DW +: AW];
  assign first_addr = rss_pkg::start_addr(base_val, disp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      pend_q <= mask;
    end else if (busy_q) begin
      if (!sel_any)     busy_q <= 1'b0;
      else if (wr_fire) pend_q <= pend_q & ~sel_oh;
    end
  end

  rss_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(first_addr),
    .step(wr_fire), .ptr(mem_addr)
  );

  assign mem_we    = busy_q && sel_any;
  assign done      = busy_q && !sel_any;
  assign busy      = busy_q;
  assign mem_wdata = regs_in[int'(sel_idx)*DW +: DW];
endmodule

// File: rtl/regstore_seq_chk.sv
module regstore_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [NREG-1:0] mask,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_we,
  input logic            mem_ready,
  input logic            busy,
  input logic            done
);
  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy && !done);                                    // R1
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ready) |=> (!mem_we || mem_addr == $past(mem_addr) + AW'(4))); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr)));    // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));                                   // R7
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mask == '0) |=> (done && !mem_we));        // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);                           // R9
endmodule

bind regstore_seq regstore_seq_chk #(.NREG(NREG), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_ready(mem_ready), .busy(busy), .done(done)
);

// File: tb/test_regstore_seq.sv
module test_regstore_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  mask = '0;
  logic [2:0]   base_sel = '0;
  logic [15:0]  disp = '0;
  logic [511:0] regs_in;
  logic [23:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic         mem_we;
  logic         mem_ready = 1'b1;
  logic         busy, done;

  int tests = 0, fails = 0;
  int rmode = 0, tick = 0;
  logic [23:0] exp_a[$];
  logic [31:0] exp_d[$];

  always #5 clk = ~clk;

  regstore_seq i_regstore_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .base_sel(base_sel),
    .disp(disp), .regs_in(regs_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_ready(mem_ready), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    tick++;
    mem_ready = (rmode == 0) ? 1'b1 : ((tick % 3) != 1);
  end

  // monitor: pop expected word on every accepted write
  always @(negedge clk) begin
    if (rst_n && mem_we && mem_ready) begin
      if (exp_a.size() == 0) begin
        check(0, "R3/R9 unexpected write", mem_addr, 0);
      end else begin
        logic [23:0] ea;
        logic [31:0] ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        check(mem_addr == ea, "R2/R4 address", mem_addr, ea);
        check(mem_wdata == ed, "R3 data", mem_wdata, ed);
      end
    end
  end

  function automatic logic [31:0] rv(input int i);
    return regs_in[i*32 +: 32];
  endfunction

  // driver: push expected items, issue start, optionally poke start mid-burst
  task automatic run_op(input logic [15:0] m, input logic [2:0] b, input logic [15:0] d,
                        input int poke_at, input int exp_cycles);
    logic [23:0] a;
    int n = 0, cyc;
    a = rv(8 + b)[23:0] + {{8{d[15]}}, d};
    for (int i = 0; i < 16; i++)
      if (m[i]) begin
        exp_a.push_back(a);
        exp_d.push_back(rv(i));
        a = a + 24'd4;
        n++;
      end
    @(negedge clk);
    mask = m; base_sel = b; disp = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 500) begin
      if (cyc == poke_at) begin
        start = 1'b1; mask = 16'hFFFF; base_sel = 3'd0; disp = 16'h0100;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (exp_cycles > 0)
      check(cyc == exp_cycles, (m == 0) ? "R8 done timing" : "R5 done timing", cyc, exp_cycles);
    check(exp_a.size() == 0, "R3 all words written", exp_a.size(), 0);
    @(negedge clk);
    check(!busy && !done, "R7 idle after done", {busy, done}, 0);
    repeat (3) @(negedge clk);
    check(!mem_we && exp_a.size() == 0, "R9 no extra writes", mem_we, 0);
  endtask

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs_in[i*32 +: 32] = 32'h1000_0000 * (i + 1) ^ (32'h0137_9BDF + 32'h0101_0101 * i);
    regs_in[14*32 +: 32] = 32'h7700_1200;   // A6
    regs_in[15*32 +: 32] = 32'hABFF_FFF8;   // A7 near top
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_we, "R1 reset state", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_we, "R1 after release", {busy, done, mem_we}, 0);

    run_op(16'h30F1, 3'd6, 16'h0028, 0, 8);   // R2 R3 R5: seven regs, 0x28
    run_op(16'h0000, 3'd6, 16'h0028, 0, 1);   // R8 zero mask
    run_op(16'h8001, 3'd6, 16'hFFF0, 0, 3);   // R2 negative displacement
    run_op(16'h000F, 3'd7, 16'h0000, 0, 5);   // R4 wrap across 2^24
    rmode = 1;
    run_op(16'h30F1, 3'd6, 16'h0028, 0, 0);   // R6 stalls
    run_op(16'hFFFF, 3'd2, 16'h0004, 0, 0);   // R6 full mask with stalls
    rmode = 0;
    run_op(16'h0A50, 3'd6, 16'h0010, 2, 5);   // R9 start mid-burst ignored
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule